// File: doc/BRIEF.md
# Serial Addressed Multi-Channel Setpoint Register

This block is the digital front end of a twelve-channel, eight-bit converter. A host drives three wires: a serial data line, a shift clock and a load strobe. It shifts in a 12-bit frame that carries a 4-bit channel address and an 8-bit code. When the strobe rises, the code is stored in the addressed channel's latch. All twelve latches are presented side by side on a parallel output bus, and these stand in for the converter codes.

The three serial wires are treated as asynchronous. Each one passes through a two-flop synchronizer in the system clock domain, and the shift clock and load strobe are turned into single-cycle edge events. The oldest bit of the frame register is driven on a serial output, so several of these blocks can be chained with one shared shift clock and one shared strobe.

Top module: `sdac_setpoint_regs`

## Requirements
- R1: While `rst_n` is low, every channel code is 0x00 and `ser_dout` is 0. The frame register is cleared too.
- R2: Frame order and weights. The first four bits shifted in are the address, least significant weight first (weights 1, 2, 4, 8). The next eight bits are the code, most significant bit first (weights 128 down to 1).
- R3: A load with address value n, where n is from 1 to 12, writes the code into channel n only. Channel n occupies bits `[8n-1:8n-8]` of `chan_codes`. All other channels keep their values.
- R4: A load with address value 0, 13, 14 or 15 changes no channel code.
- R5: Each rising edge of `ser_load` performs exactly one write, using the frame held at that moment. Bits shifted in while the strobe stays high cause no further write until the strobe falls and rises again.
- R6: Shift clock edges while `ser_load` is low never change any channel code.
- R7: `ser_dout` always shows the bit that entered 12 shift-clock rising edges earlier, or 0 if fewer than 12 shifts have happened since reset.
- R8: Every code value from 0x00 to 0xFF is stored and presented unchanged, including both extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and state use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Serial frame data, asynchronous |
| ser_sck | input | 1 | Shift clock, asynchronous; a rising edge shifts one bit in |
| ser_load | input | 1 | Load strobe, asynchronous; a rising edge writes the addressed latch |
| ser_dout | output | 1 | Oldest frame bit, used as the cascade output |
| chan_codes | output | 96 | Twelve 8-bit channel codes; channel n is at bits [8n-1:8n-8] |

## Verification
A corrupted frame register shows up at `ser_dout` within a single shift. On the next load it also shows up as the wrong channel or the wrong code. A wrong decode or a latch written more than once shows as a changed neighbour channel or a stale code a few system cycles after the strobe edge, because the synchronizer and edge stage add three cycles. The bench therefore sends address values whose bit reversal is a different channel or an unused code. It holds the strobe high while shifting a new frame in. It also compares the cascade bit after every frame, which catches a wrong shift direction or a wrong synchronizer alignment before any latch is touched.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // Default geometry of the setpoint register.
  localparam int unsigned SDAC_NUM_CH   = 12;
  localparam int unsigned SDAC_DATA_W   = 8;
  localparam int unsigned SDAC_ADDR_W   = 4;
  localparam int unsigned SDAC_SYNC_LEN = 2;

  // Index of each raw serial wire inside the synchronizer vector.
  localparam int unsigned SDAC_PIN_DIN  = 0;
  localparam int unsigned SDAC_PIN_SCK  = 1;
  localparam int unsigned SDAC_PIN_LOAD = 2;
  localparam int unsigned SDAC_PIN_CNT  = 3;
endpackage

// File: rtl/sdac_input_sync.sv
module sdac_input_sync
  import sdac_pkg::*;
#(
  parameter int unsigned STAGES = SDAC_SYNC_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_raw,
  input  logic sck_raw,
  input  logic load_raw,
  output logic din_s,
  output logic shift_evt,
  output logic load_evt
);
  localparam int unsigned W = SDAC_PIN_CNT;

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             raw_vec;
  logic                     sck_prev_q;
  logic                     load_prev_q;

  always_comb begin
    raw_vec                = '0;
    raw_vec[SDAC_PIN_DIN]  = din_raw;
    raw_vec[SDAC_PIN_SCK]  = sck_raw;
    raw_vec[SDAC_PIN_LOAD] = load_raw;
  end

  // Synchronizer chain: every wire goes through the same number of flops,
  // so the data bit stays aligned with its shift clock.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= raw_vec;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q  <= 1'b0;
      load_prev_q <= 1'b0;
    end else begin
      sck_prev_q  <= chain_q[STAGES-1][SDAC_PIN_SCK];
      load_prev_q <= chain_q[STAGES-1][SDAC_PIN_LOAD];
    end
  end

  assign din_s     = chain_q[STAGES-1][SDAC_PIN_DIN];
  assign shift_evt = chain_q[STAGES-1][SDAC_PIN_SCK]  & ~sck_prev_q;
  assign load_evt  = chain_q[STAGES-1][SDAC_PIN_LOAD] & ~load_prev_q;
endmodule

// File: rtl/sdac_frame_shifter.sv
module sdac_frame_shifter #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] frame_q,
  output logic             msb_out
);
  // New bits enter at index 0 and move toward index WIDTH-1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame_q <= '0;
    else if (shift_en) frame_q <= {frame_q[WIDTH-2:0], bit_in};
  end

  assign msb_out = frame_q[WIDTH-1];
endmodule

// File: rtl/sdac_latch_bank.sv
module sdac_latch_bank #(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        wr_sel,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_CH*DATA_W-1:0] codes
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic [DATA_W-1:0] code_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         code_q <= '0;
        else if (wr_sel[c]) code_q <= wr_data;
      end

      assign codes[c*DATA_W +: DATA_W] = code_q;
    end
  endgenerate
endmodule

// File: rtl/sdac_setpoint_regs.sv
module sdac_setpoint_regs
  import sdac_pkg::*;
#(
  parameter int unsigned NUM_CH   = SDAC_NUM_CH,
  parameter int unsigned DATA_W   = SDAC_DATA_W,
  parameter int unsigned ADDR_W   = SDAC_ADDR_W,
  parameter int unsigned SYNC_LEN = SDAC_SYNC_LEN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_din,
  input  logic                     ser_sck,
  input  logic                     ser_load,
  output logic                     ser_dout,
  output logic [NUM_CH*DATA_W-1:0] chan_codes
);
  localparam int unsigned FRAME_W = ADDR_W + DATA_W;

  // The address field sits in the top ADDR_W bits. Its first-shifted bit
  // (top of the register) carries weight 1, so the field is read bit-reversed.
  function automatic logic [ADDR_W-1:0] field_addr(input logic [FRAME_W-1:0] f);
    logic [ADDR_W-1:0] a;
    for (int i = 0; i < int'(ADDR_W); i++) a[i] = f[FRAME_W-1-i];
    return a;
  endfunction

  // The code field is the low DATA_W bits, in natural weight order.
  function automatic logic [DATA_W-1:0] field_code(input logic [FRAME_W-1:0] f);
    return f[DATA_W-1:0];
  endfunction

  // Address values 1..NUM_CH are the only ones that name a channel.
  function automatic logic is_chan_code(input logic [ADDR_W-1:0] a);
    return (int'(a) >= 1) && (int'(a) <= int'(NUM_CH));
  endfunction

  // Address value n selects channel slot n-1.
  function automatic logic [NUM_CH-1:0] chan_select(input logic [ADDR_W-1:0] a);
    logic [NUM_CH-1:0] s;
    s = '0;
    for (int c = 0; c < int'(NUM_CH); c++)
      if (int'(a) == c + 1) s[c] = 1'b1;
    return s;
  endfunction

  // Named internal events, used by the bound checker.
  logic               din_s;
  logic               shift_evt;
  logic               load_evt;
  logic [FRAME_W-1:0] sr_q;
  logic [ADDR_W-1:0]  frame_addr;
  logic [DATA_W-1:0]  frame_code;
  logic               addr_valid;
  logic [NUM_CH-1:0]  wr_sel;

  sdac_input_sync #(
    .STAGES (SYNC_LEN)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .din_raw   (ser_din),
    .sck_raw   (ser_sck),
    .load_raw  (ser_load),
    .din_s     (din_s),
    .shift_evt (shift_evt),
    .load_evt  (load_evt)
  );

  sdac_frame_shifter #(
    .WIDTH (FRAME_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_evt),
    .bit_in   (din_s),
    .frame_q  (sr_q),
    .msb_out  (ser_dout)
  );

  assign frame_addr = field_addr(sr_q);
  assign frame_code = field_code(sr_q);
  assign addr_valid = is_chan_code(frame_addr);
  assign wr_sel     = load_evt ? chan_select(frame_addr) : '0;

  sdac_latch_bank #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel),
    .wr_data (frame_code),
    .codes   (chan_codes)
  );
endmodule

// File: rtl/sdac_setpoint_checker.sv
module sdac_setpoint_checker #(
  parameter int unsigned NUM_CH  = 12,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned FRAME_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     shift_evt,
  input logic                     load_evt,
  input logic                     addr_valid,
  input logic [NUM_CH-1:0]        wr_sel,
  input logic [FRAME_W-1:0]       sr_q,
  input logic                     ser_dout,
  input logic [NUM_CH*DATA_W-1:0] chan_codes
);
  // R1: leaving reset, all codes are zero and the cascade bit is low
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (chan_codes == '0) && !ser_dout);

  // R3: a write to a valid address touches exactly one channel
  p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && addr_valid) |-> ($countones(wr_sel) == 1));

  // R4: unused address codes leave every channel as it was
  p_bad_addr_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !addr_valid) |=> $stable(chan_codes));

  // R5: one strobe edge gives one write event, never two in a row
  p_one_write_per_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !load_evt);

  // R6: without a load event no channel code moves
  p_no_write_without_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(chan_codes));

  // R7: after a shift the cascade bit is the bit that sat just below the top
  p_cascade_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (ser_dout == $past(sr_q[FRAME_W-2])));

  // R7: without a shift the cascade bit holds
  p_cascade_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(ser_dout));
endmodule

bind sdac_setpoint_regs sdac_setpoint_checker #(
  .NUM_CH  (NUM_CH),
  .DATA_W  (DATA_W),
  .FRAME_W (FRAME_W)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_evt  (shift_evt),
  .load_evt   (load_evt),
  .addr_valid (addr_valid),
  .wr_sel     (wr_sel),
  .sr_q       (sr_q),
  .ser_dout   (ser_dout),
  .chan_codes (chan_codes)
);

// File: tb/sdac_setpoint_regs_bench.sv
module sdac_setpoint_regs_bench;
  localparam int NCH = 12;
  localparam int DW  = 8;
  localparam int WATCHDOG_CYCLES = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ser_din = 1'b0;
  logic          ser_sck = 1'b0;
  logic          ser_load = 1'b0;
  logic          ser_dout;
  logic [NCH*DW-1:0] chan_codes;

  always #10 clk = ~clk;  // 50 MHz

  sdac_setpoint_regs u_sdac_setpoint_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_din    (ser_din),
    .ser_sck    (ser_sck),
    .ser_load   (ser_load),
    .ser_dout   (ser_dout),
    .chan_codes (chan_codes)
  );

  typedef struct {
    string             req;
    logic [NCH*DW-1:0] codes;
    logic              dout;
  } sb_item_t;

  sb_item_t    sb_q[$];
  logic        hist[$];          // every bit shifted in since reset
  logic [DW-1:0] model[NCH];     // expected channel codes
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  function automatic logic [NCH*DW-1:0] model_flat();
    logic [NCH*DW-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*DW +: DW] = model[c];
    return v;
  endfunction

  function automatic logic model_dout();
    if (hist.size() < 12) return 1'b0;
    return hist[hist.size()-12];
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_din = b;
    cycles(4);
    ser_sck = 1'b1;
    cycles(5);
    ser_sck = 1'b0;
    cycles(4);
    hist.push_back(b);
  endtask

  // R2 framing: address weight 1 first, then code MSB first.
  task automatic shift_frame(input int addr, input logic [DW-1:0] code);
    for (int i = 0; i < 4; i++) shift_bit(1'((addr >> i) & 1));
    for (int i = DW-1; i >= 0; i--) shift_bit(code[i]);
  endtask

  // Model of a strobe edge: decode the last twelve bits seen.
  task automatic model_load();
    int s;
    int a;
    logic [DW-1:0] d;
    s = hist.size();
    a = 0;
    d = '0;
    for (int i = 0; i < 4; i++) a += int'(hist[s-12+i]) << i;
    for (int k = 0; k < DW; k++) d[DW-1-k] = hist[s-8+k];
    if (a >= 1 && a <= NCH) model[a-1] = d;
  endtask

  task automatic push_item(input string req);
    sb_item_t it;
    it.req   = req;
    it.codes = model_flat();
    it.dout  = model_dout();
    sb_q.push_back(it);
    cycles(6);
  endtask

  task automatic pulse_load();
    ser_load = 1'b1;
    cycles(6);
    model_load();
    ser_load = 1'b0;
    cycles(6);
  endtask

  task automatic send(input int addr, input logic [DW-1:0] code, input string req);
    shift_frame(addr, code);
    pulse_load();
    push_item(req);
  endtask

  // Monitor: compares each expected item against the ports.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        sb_item_t it;
        cycles(2);
        it = sb_q.pop_front();
        n_cmp++;
        if (chan_codes !== it.codes) begin
          n_bad++;
          $display("FAIL %s codes: actual %h expected %h", it.req, chan_codes, it.codes);
        end
        n_cmp++;
        if (ser_dout !== it.dout) begin
          n_bad++;
          $display("FAIL %s ser_dout (R7): actual %b expected %b", it.req, ser_dout, it.dout);
        end
      end
    end
  end

  // Watchdog
  initial begin
    for (int i = 0; i < WATCHDOG_CYCLES; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) model[c] = '0;
    cycles(3);
    // R1: reset state
    n_cmp++;
    if (chan_codes !== '0 || ser_dout !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: actual %h/%b expected 0/0", chan_codes, ser_dout);
    end
    rst_n = 1'b1;
    cycles(3);
    push_item("R1");

    // R3: basic writes to the two end channels and a middle one
    send(1,  8'hA5, "R3 ch1");
    send(12, 8'h3C, "R3 ch12");
    send(5,  8'h81, "R3 ch5");
    // R2: address 11 reversed would be 13; address 1 reversed would be 8
    send(11, 8'h5A, "R2 ch11");
    send(1,  8'h17, "R2 ch1 rewrite");
    send(6,  8'h01, "R2 code weight");
    // R8: extremes
    send(7,  8'hFF, "R8 ff");
    send(8,  8'h00, "R8 00");
    send(7,  8'h00, "R8 back to 00");
    send(8,  8'hFF, "R8 ff ch8");
    // R4: unused address codes
    send(0,  8'h77, "R4 addr0");
    send(13, 8'h77, "R4 addr13");
    send(14, 8'h77, "R4 addr14");
    send(15, 8'h77, "R4 addr15");
    // R6: shift without strobe
    shift_frame(2, 8'hC3);
    push_item("R6 no load");
    shift_frame(9, 8'h99);
    push_item("R6 no load 2");
    // R5: hold the strobe high and shift a new frame in
    shift_frame(3, 8'h11);
    ser_load = 1'b1;
    cycles(6);
    model_load();                 // writes ch3 = 0x11
    shift_frame(4, 8'h44);        // strobe still high
    push_item("R5 held strobe");
    ser_load = 1'b0;
    cycles(6);
    push_item("R5 after release");
    pulse_load();                 // a second edge now writes ch4
    push_item("R5 second edge");
    // R7: odd bit count, cascade bit from 12 shifts ago
    shift_bit(1'b1);
    push_item("R7 odd shift");
    shift_bit(1'b0);
    shift_bit(1'b1);
    push_item("R7 odd shift 2");
    send(10, 8'hE7, "R3 ch10 after misalign");

    while (sb_q.size() != 0) cycles(1);
    cycles(4);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule